// File: doc/BRIEF.md
# I2C Slave Front End with Command Mailbox

This block is the two-wire serial front end of a memory-mapped secure storage device. It watches SCL and SDA through a synchronizer clocked by the system clock. It recognises START, repeated START and STOP, and answers only when the address byte carries its programmed 7-bit device address. It never drives SCL and never starts a transfer. It pulls SDA low or lets it float, and never drives it high.

A write transfer carries the device byte, then a high and a low memory address byte, then data bytes. Each data byte goes out on a simple write strobe, and the memory address advances after each byte. A read transfer returns bytes from the current memory address, most significant bit first, until the master answers with NACK. The address 0xFE00 is a mailbox, and its role depends on the direction. Bytes written there are handed to a command buffer. Bytes read there are taken from a response buffer. While the mailbox is in use, the address does not advance.

When the device is in standby or sleep and its address is seen on the bus, the block raises a wake request. Command processing, the storage array and power sequencing lie outside this block. They connect through the strobe ports.

Top module: `i2c_mailbox_slave`

## Requirements
- R1: After reset, sda_oe, wake_req, mem_we, mem_re, cmd_valid and rsp_pop are all 0.
- R2: The block acknowledges an address byte, by holding SDA low during the ninth clock, only when bits 7..1 of that byte equal dev_addr. With any other address it leaves SDA released for the whole transfer, and data bytes that follow cause no write strobe.
- R3: Bit 0 of the address byte selects the direction. A 0 starts a write, with address and data bytes from the master. A 1 starts a read, in which the block sends bytes.
- R4: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. A repeated START at any point restarts the sequence at the address byte.
- R5: In a write, the first byte after the address byte is memory address bits 15..8 and the second is bits 7..0. Each later byte is acknowledged and pulses mem_we with mem_wdata at mem_addr. mem_addr then advances by one.
- R6: A data byte written while the memory address is 0xFE00 pulses cmd_valid with the byte on cmd_data. It does not pulse mem_we, and the address stays at 0xFE00.
- R7: In a read, each byte is taken from mem_rdata at the current address and shifted out MSB first, and the address advances by one. A master ACK continues the transfer. A master NACK ends it with SDA released.
- R8: A read while the address is 0xFE00 takes each byte from rsp_data with a one-cycle rsp_pop pulse, and the address stays at 0xFE00.
- R9: wake_req pulses for one clock when the address byte matches while asleep is 1. It does not pulse for a matching address while asleep is 0, and it does not pulse for a non-matching address.
- R10: SDA is only ever pulled low (sda_oe=1) or released. sda_oe changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| dev_addr | input | 7 | Programmed device address |
| asleep | input | 1 | Device is in standby or sleep |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| wake_req | output | 1 | One-cycle wake request |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Pulses when a memory byte is taken for sending |
| mem_addr | output | 16 | Current memory address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data for mem_addr, valid without delay |
| cmd_valid | output | 1 | Command-buffer push strobe |
| cmd_data | output | 8 | Command byte |
| rsp_pop | output | 1 | Response-buffer pop strobe |
| rsp_data | input | 8 | Head of the response buffer |

## Verification
The wake request and the acknowledge of the address byte are raised on the same system clock edge: the falling SCL edge that follows the eighth address bit. The bench provokes this by addressing the block while asleep is high. It then checks two things: that exactly one wake pulse appears, and that the master still sees the ACK on that same byte. It repeats the transfer with a wrong address while asleep, and with the right address while awake, and expects no wake pulse in either case. An assertion ties every wake pulse to an active SDA pull-down in the same cycle.

// File: rtl/i2c_mailbox_slave.sv
module i2c_mailbox_slave #(
  parameter int          AW        = 16,
  parameter logic [15:0] MBOX_ADDR = 16'hFE00
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic [6:0]    dev_addr,
  input  logic          asleep,
  output logic          sda_oe,
  output logic          wake_req,
  output logic          mem_we,
  output logic          mem_re,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  input  logic [7:0]    mem_rdata,
  output logic          cmd_valid,
  output logic [7:0]    cmd_data,
  output logic          rsp_pop,
  input  logic [7:0]    rsp_data
);
  typedef enum logic [2:0] {S_IDLE, S_DEV, S_AHI, S_ALO, S_WR, S_RD} st_t;

  logic [1:0]    scl_sy, sda_sy;
  logic          scl_q, sda_q;
  st_t           st;
  logic [3:0]    cnt;
  logic [7:0]    sr;
  logic          rw, nack;
  logic [AW-1:0] addr;

  wire scl_s   = scl_sy[1];
  wire sda_s   = sda_sy[1];
  wire scl_rise = scl_s & ~scl_q;
  wire scl_fall = ~scl_s & scl_q;
  wire start   = scl_s & scl_q & sda_q & ~sda_s;
  wire stop    = scl_s & scl_q & ~sda_q & sda_s;
  wire mbox    = (addr == AW'(MBOX_ADDR));
  wire [7:0] tx_byte = mbox ? rsp_data : mem_rdata;

  assign mem_addr  = addr;
  assign mem_wdata = sr;
  assign cmd_data  = sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      sr        <= '0;
      rw        <= 1'b0;
      nack      <= 1'b0;
      addr      <= '0;
      sda_oe    <= 1'b0;
      wake_req  <= 1'b0;
      mem_we    <= 1'b0;
      mem_re    <= 1'b0;
      cmd_valid <= 1'b0;
      rsp_pop   <= 1'b0;
    end else begin
      wake_req  <= 1'b0;
      mem_we    <= 1'b0;
      mem_re    <= 1'b0;
      cmd_valid <= 1'b0;
      rsp_pop   <= 1'b0;
      if (start) begin
        st     <= S_DEV;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop) begin
        st     <= S_IDLE;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (st != S_IDLE) begin
        if (scl_rise) begin
          if (st != S_RD && cnt < 4'd8) sr <= {sr[6:0], sda_s};
          if (st == S_RD && cnt == 4'd8) nack <= sda_s;
          if (cnt != 4'd9) cnt <= cnt + 4'd1;
        end else if (scl_fall) begin
          if (st == S_RD) begin
            if (cnt >= 4'd1 && cnt <= 4'd7) begin
              sr     <= {sr[6:0], 1'b0};
              sda_oe <= ~sr[6];
            end else if (cnt == 4'd8) begin
              sda_oe <= 1'b0;
              if (!mbox) addr <= addr + 1'b1;
            end else if (cnt == 4'd9) begin
              if (nack) st <= S_IDLE;
              else begin
                cnt     <= '0;
                sr      <= tx_byte;
                sda_oe  <= ~tx_byte[7];
                rsp_pop <= mbox;
                mem_re  <= ~mbox;
              end
            end
          end else if (cnt == 4'd8) begin
            case (st)
              S_DEV: begin
                if (sr[7:1] == dev_addr) begin
                  sda_oe   <= 1'b1;
                  rw       <= sr[0];
                  wake_req <= asleep;
                end else begin
                  st <= S_IDLE;
                end
              end
              S_AHI: begin
                sda_oe     <= 1'b1;
                addr[AW-1:8] <= sr[AW-9:0];
              end
              S_ALO: begin
                sda_oe    <= 1'b1;
                addr[7:0] <= sr;
              end
              default: begin
                sda_oe    <= 1'b1;
                cmd_valid <= mbox;
                mem_we    <= ~mbox;
              end
            endcase
          end else if (cnt == 4'd9) begin
            sda_oe <= 1'b0;
            cnt    <= '0;
            case (st)
              S_DEV: begin
                if (rw) begin
                  st      <= S_RD;
                  sr      <= tx_byte;
                  sda_oe  <= ~tx_byte[7];
                  rsp_pop <= mbox;
                  mem_re  <= ~mbox;
                end else begin
                  st <= S_AHI;
                end
              end
              S_AHI:   st <= S_ALO;
              S_ALO:   st <= S_WR;
              default: if (!mbox) addr <= addr + 1'b1;
            endcase
          end
        end
      end
    end
  end
endmodule

// File: rtl/i2c_mailbox_slave_chk.sv
module i2c_mailbox_slave_chk #(
  parameter int          AW        = 16,
  parameter logic [15:0] MBOX_ADDR = 16'hFE00
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_i,
  input logic          asleep,
  input logic          sda_oe,
  input logic          wake_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          cmd_valid,
  input logic          rsp_pop
);
  assert_we_not_mailbox_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr != AW'(MBOX_ADDR)) && !cmd_valid);

  assert_cmd_addr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> mem_addr == AW'(MBOX_ADDR));

  assert_pop_at_mailbox_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_pop |-> mem_addr == AW'(MBOX_ADDR));

  assert_wake_with_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> asleep && sda_oe);

  assert_wake_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |=> !wake_req);

  assert_oe_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_i);
endmodule

bind i2c_mailbox_slave i2c_mailbox_slave_chk #(.AW(AW), .MBOX_ADDR(MBOX_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .asleep(asleep), .sda_oe(sda_oe),
  .wake_req(wake_req), .mem_we(mem_we), .mem_addr(mem_addr),
  .cmd_valid(cmd_valid), .rsp_pop(rsp_pop)
);

// File: tb/sim_i2c_mailbox_slave.sv
module sim_i2c_mailbox_slave;
  localparam int Q = 6;

  logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1, asleep = 1'b0;
  logic [6:0] dev_addr = 7'h52;
  logic sda_oe, wake_req, mem_we, mem_re, cmd_valid, rsp_pop;
  logic [15:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata, cmd_data, rsp_data;
  wire sda_bus = sda_m & ~sda_oe;

  logic [7:0] mem [0:255];
  logic [7:0] cmd_log [0:7];
  logic [7:0] rsp_buf [0:3];
  logic [1:0] rsp_idx = '0;
  int wr_cnt = 0, cmd_cnt = 0, pop_cnt = 0, wake_cnt = 0, viol = 0;
  int errors = 0, checks = 0;
  logic prev_oe = 1'b0;

  always #10 clk = ~clk;

  assign mem_rdata = mem[mem_addr[7:0]];
  assign rsp_data  = rsp_buf[rsp_idx];

  i2c_mailbox_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .dev_addr(dev_addr),
    .asleep(asleep), .sda_oe(sda_oe), .wake_req(wake_req), .mem_we(mem_we),
    .mem_re(mem_re), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .cmd_valid(cmd_valid), .cmd_data(cmd_data), .rsp_pop(rsp_pop), .rsp_data(rsp_data)
  );

  always @(posedge clk) begin
    if (mem_we) begin mem[mem_addr[7:0]] <= mem_wdata; wr_cnt <= wr_cnt + 1; end
    if (cmd_valid) begin cmd_log[cmd_cnt[2:0]] <= cmd_data; cmd_cnt <= cmd_cnt + 1; end
    if (rsp_pop) begin rsp_idx <= rsp_idx + 2'd1; pop_cnt <= pop_cnt + 1; end
    if (wake_req) wake_cnt <= wake_cnt + 1;
  end

  always @(negedge clk) begin
    if (rst_n && sda_oe != prev_oe && scl_m) viol = viol + 1;
    prev_oe = sda_oe;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    w(Q); sda_m = 1'b1; w(Q); scl_m = 1'b1; w(2*Q); sda_m = 1'b0; w(2*Q); scl_m = 1'b0;
  endtask

  task automatic i2c_stop();
    w(Q); sda_m = 1'b0; w(Q); scl_m = 1'b1; w(2*Q); sda_m = 1'b1; w(2*Q);
  endtask

  task automatic clk_bit(input bit b, output bit s);
    w(Q); sda_m = b; w(Q); scl_m = 1'b1; w(Q); s = sda_bus; w(Q); scl_m = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    bit s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic recv_byte(input bit ack, output logic [7:0] b);
    bit s;
    for (int i = 7; i >= 0; i--) begin clk_bit(1'b1, s); b[i] = s; end
    clk_bit(~ack, s);
  endtask

  task automatic finish_up();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic t_reset();
    chk(sda_oe == 0 && wake_req == 0 && mem_we == 0 && mem_re == 0 && cmd_valid == 0 && rsp_pop == 0,
        "R1", "outputs after reset", {sda_oe, wake_req, mem_we, mem_re, cmd_valid, rsp_pop}, 0);
  endtask

  task automatic t_write();
    bit a;
    int w0 = wr_cnt;
    i2c_start();
    send_byte({dev_addr, 1'b0}, a); chk(a, "R2", "ack of matching write address", a, 1);
    send_byte(8'h00, a); chk(a, "R5", "ack of high address", a, 1);
    send_byte(8'h10, a); chk(a, "R5", "ack of low address", a, 1);
    send_byte(8'hA1, a); chk(a, "R3", "ack of data in write direction", a, 1);
    send_byte(8'hB2, a);
    send_byte(8'hC3, a);
    i2c_stop();
    w(4);
    chk(wr_cnt - w0 == 3, "R5", "write strobes", wr_cnt - w0, 3);
    chk(mem[8'h10] == 8'hA1 && mem[8'h11] == 8'hB2 && mem[8'h12] == 8'hC3, "R5", "incremented writes",
        {mem[8'h10], mem[8'h11], mem[8'h12]}, 24'hA1B2C3);
  endtask

  task automatic t_read();
    bit a;
    logic [7:0] b;
    i2c_start();
    send_byte({dev_addr, 1'b0}, a);
    send_byte(8'h00, a);
    send_byte(8'h20, a);
    i2c_start();
    send_byte({dev_addr, 1'b1}, a); chk(a, "R4", "ack after repeated START", a, 1);
    for (int i = 0; i < 3; i++) begin
      recv_byte(i != 2, b);
      chk(b == (8'(8'h20 + i) ^ 8'h5A), "R7", "read byte", b, 8'(8'h20 + i) ^ 8'h5A);
    end
    w(2);
    chk(sda_oe == 0, "R7", "SDA released after NACK", sda_oe, 0);
    i2c_stop();
  endtask

  task automatic t_wrong_addr();
    bit a;
    int w0 = wr_cnt;
    i2c_start();
    send_byte({dev_addr ^ 7'h01, 1'b0}, a); chk(!a, "R2", "no ack for foreign address", a, 0);
    send_byte(8'h00, a); chk(!a, "R2", "no ack for following byte", a, 0);
    send_byte(8'h10, a);
    send_byte(8'hEE, a);
    i2c_stop();
    w(4);
    chk(wr_cnt == w0, "R2", "no write after foreign address", wr_cnt - w0, 0);
  endtask

  task automatic t_restart_addr();
    bit a;
    i2c_start();
    send_byte({dev_addr, 1'b0}, a);
    send_byte(8'h00, a);
    i2c_start();
    send_byte({dev_addr, 1'b0}, a);
    send_byte(8'h00, a);
    send_byte(8'h40, a);
    send_byte(8'h77, a);
    i2c_stop();
    w(4);
    chk(mem[8'h40] == 8'h77, "R4", "repeated START restarts address phase", mem[8'h40], 8'h77);
  endtask

  task automatic t_mbox_write();
    bit a;
    int w0 = wr_cnt;
    i2c_start();
    send_byte({dev_addr, 1'b0}, a);
    send_byte(8'hFE, a);
    send_byte(8'h00, a);
    send_byte(8'h11, a); chk(a, "R6", "ack of mailbox byte", a, 1);
    send_byte(8'h22, a);
    send_byte(8'h33, a);
    i2c_stop();
    w(4);
    chk(cmd_cnt == 3, "R6", "command pushes", cmd_cnt, 3);
    chk(cmd_log[0] == 8'h11 && cmd_log[1] == 8'h22 && cmd_log[2] == 8'h33, "R6", "command bytes",
        {cmd_log[0], cmd_log[1], cmd_log[2]}, 24'h112233);
    chk(wr_cnt == w0, "R6", "no memory write at mailbox", wr_cnt - w0, 0);
  endtask

  task automatic t_mbox_read();
    bit a;
    logic [7:0] b0, b1;
    i2c_start();
    send_byte({dev_addr, 1'b1}, a);
    recv_byte(1'b1, b0);
    recv_byte(1'b0, b1);
    i2c_stop();
    w(4);
    chk(b0 == 8'hC3 && b1 == 8'h3C, "R8", "response bytes at held mailbox address", {b0, b1}, 16'hC33C);
    chk(pop_cnt == 2, "R8", "response pops", pop_cnt, 2);
  endtask

  task automatic t_wake();
    bit a;
    asleep = 1'b1;
    i2c_start();
    send_byte({dev_addr, 1'b0}, a);
    i2c_stop();
    w(4);
    chk(wake_cnt == 1, "R9", "wake on match while asleep", wake_cnt, 1);
    chk(a, "R9", "ack in the wake cycle", a, 1);
    i2c_start();
    send_byte({dev_addr ^ 7'h10, 1'b0}, a);
    i2c_stop();
    w(4);
    chk(wake_cnt == 1, "R9", "no wake on foreign address", wake_cnt, 1);
    asleep = 1'b0;
    i2c_start();
    send_byte({dev_addr, 1'b0}, a);
    i2c_stop();
    w(4);
    chk(wake_cnt == 1, "R9", "no wake while awake", wake_cnt, 1);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
    rsp_buf[0] = 8'hC3; rsp_buf[1] = 8'h3C; rsp_buf[2] = 8'h00; rsp_buf[3] = 8'h00;
    w(5);
    t_reset();
    rst_n = 1'b1;
    w(5);
    t_write();
    t_read();
    t_wrong_addr();
    t_restart_addr();
    t_mbox_write();
    t_mbox_read();
    t_wake();
    chk(viol == 0, "R10", "sda_oe changes while SCL high", viol, 0);
    finish_up();
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", "run did not finish", 0, 1);
    finish_up();
  end
endmodule